// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed and Guarded Control

This block is a watchdog for a small register bus. Software picks a timeout by writing a 3-bit code into a readable control register. It keeps the system alive by writing a fixed key value into a write-only feed register. If no valid feed arrives before the selected timeout runs out, the block raises a reset request for a fixed number of clock cycles. It then returns itself to the disabled state.

The control register is guarded. A new setting is taken only shortly after a valid feed, so a stray write cannot quietly disable or stretch the watchdog. A millisecond timebase and a microsecond timebase are divided down from the system clock. Their ratios are parameters, so a simulation can run with small counts.

Top module: `guard_timer`

## Requirements
- R1: After reset the control code reads 0. While the code is 0, the watchdog is off and `wd_rst_req` never rises.
- R2: Codes 1, 2, 3, 5, 6 and 7 select timeouts of 250, 500, 1000, 2000, 4000 and 8000 ms. Time is counted in units of `CYC_PER_US*US_PER_MS` clock cycles per ms. `wd_rst_req` first reads high exactly `timeout_ms*CYC_PER_US*US_PER_MS` cycles after the clock edge that last reloaded the countdown.
- R3: A write of the value 5 to the feed register (`bus_sel`=1) reloads the countdown with the full timeout of the current code. It also opens the control-write window.
- R4: A feed write of any value other than 5 changes neither the countdown nor the window.
- R5: A control write (`bus_sel`=0) is taken only if it lands on a clock edge no more than `WINDOW_US*CYC_PER_US` cycles after the edge of the last valid feed. A control write arriving later, or with no feed since reset, leaves the old code in place.
- R6: A control write of the reserved code 4 is ignored, even inside the window.
- R7: An accepted control write reloads the countdown with the timeout of the newly written code.
- R8: A read with `bus_sel`=0 returns the control code on the 3-bit read bus. A read with `bus_sel`=1, or with no read strobe, returns 0.
- R9: On expiry, `wd_rst_req` stays high for exactly `PULSE_CYC` cycles, and the control code reads 0 from the first of those cycles.
- R10: Asserting `rst_n` low at any time clears the control code and drops `wd_rst_req` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register chip select |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe, combinational read data |
| bus_sel | input | 1 | Register select: 0 control, 1 feed |
| bus_wdata | input | 3 | Write data |
| bus_rdata | output | 3 | Read data |
| wd_rst_req | output | 1 | Reset request pulse on timeout |

## Verification
The hardest behaviour to reach is the edge of the control window. A control write must land exactly on the last permitted cycle after a feed, or on the first cycle after it. Directed tests place the control write at precisely those two distances from the feed edge. Random rounds then sweep the feed-to-write distance across both sides of the limit, mixed with reserved codes and wrong feed values. Each timeout code is also run to expiry, and the reset pulse is sampled one cycle before and one cycle at the predicted edge.

// File: rtl/guard_timer_pkg.sv
`timescale 1ns/1ps
package guard_timer_pkg;
  localparam logic [2:0] FEED_KEY  = 3'd5;
  localparam logic [2:0] CODE_OFF  = 3'd0;
  localparam logic [2:0] CODE_RSVD = 3'd4;
  localparam logic       SEL_CTRL  = 1'b0;
  localparam logic       SEL_FEED  = 1'b1;

  typedef struct packed {
    logic       ctrl_wr;
    logic       feed_ok;
    logic [2:0] data;
  } gt_req_t;
endpackage

// File: rtl/gt_rst_sync.sv
`timescale 1ns/1ps
module gt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gt_divider.sv
`timescale 1ns/1ps
module gt_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gt_window.sv
`timescale 1ns/1ps
module gt_window #(
  parameter int unsigned WINDOW_US  = 30,
  parameter int unsigned CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic feed_ok,
  output logic win_open
);
  localparam int unsigned WW = $clog2(WINDOW_US + 1);
  localparam logic [WW-1:0] WFULL = WW'(WINDOW_US);

  logic [WW-1:0] win_q, win_d;
  logic          us_tick;

  assign win_open = (win_q != '0);

  gt_divider #(.DIV(CYC_PER_US)) u_us_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (feed_ok),
    .en   (win_open),
    .tick (us_tick)
  );

  always_comb begin
    win_d = win_q;
    if (feed_ok)      win_d = WFULL;
    else if (us_tick) win_d = win_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/gt_ctrl.sv
`timescale 1ns/1ps
module gt_ctrl
  import guard_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gt_req_t    req,
  input  logic       win_open,
  input  logic       expire,
  output logic [2:0] ctrl_q,
  output logic       accept
);
  logic [2:0] ctrl_d;

  assign accept = req.ctrl_wr && win_open && (req.data != CODE_RSVD);

  always_comb begin
    ctrl_d = ctrl_q;
    if (expire)      ctrl_d = CODE_OFF;
    else if (accept) ctrl_d = req.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CODE_OFF;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/gt_countdown.sv
`timescale 1ns/1ps
module gt_countdown #(
  parameter int unsigned CYC_PER_MS = 200000,
  parameter int unsigned BASE_MS    = 250,
  parameter int unsigned PULSE_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload,
  input  logic [2:0] load_code,
  output logic       expire,
  output logic       rst_req
);
  localparam int unsigned MS_W = $clog2(BASE_MS * 32 + 1);
  localparam int unsigned PW   = $clog2(PULSE_CYC + 1);
  localparam logic [MS_W-1:0] BASE  = MS_W'(BASE_MS);
  localparam logic [PW-1:0]   PFULL = PW'(PULSE_CYC);

  function automatic logic [MS_W-1:0] code_to_ms(input logic [2:0] c);
    case (c)
      3'd1:    return BASE;
      3'd2:    return BASE << 1;
      3'd3:    return BASE << 2;
      3'd5:    return BASE << 3;
      3'd6:    return BASE << 4;
      3'd7:    return BASE << 5;
      default: return '0;
    endcase
  endfunction

  logic [MS_W-1:0] left_q, left_d;
  logic [PW-1:0]   pul_q, pul_d;
  logic            running, ms_tick;

  assign running = (left_q != '0);

  gt_divider #(.DIV(CYC_PER_MS)) u_ms_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (reload),
    .en   (running),
    .tick (ms_tick)
  );

  assign expire  = ms_tick && (left_q == MS_W'(1));
  assign rst_req = (pul_q != '0);

  always_comb begin
    left_d = left_q;
    if (reload)       left_d = code_to_ms(load_code);
    else if (ms_tick) left_d = left_q - 1'b1;
  end

  always_comb begin
    pul_d = pul_q;
    if (expire)             pul_d = PFULL;
    else if (pul_q != '0)   pul_d = pul_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pul_q  <= '0;
    end else begin
      left_q <= left_d;
      pul_q  <= pul_d;
    end
  end
endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 200,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned WINDOW_US  = 30,
  parameter int unsigned BASE_MS    = 250,
  parameter int unsigned PULSE_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cs,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [2:0] bus_wdata,
  output logic [2:0] bus_rdata,
  output logic       wd_rst_req
);
  localparam int unsigned CYC_PER_MS = CYC_PER_US * US_PER_MS;

  logic       rst_n_i;
  gt_req_t    req;
  logic       win_open, accept, expire, reload;
  logic [2:0] ctrl_q, load_code;

  gt_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  assign req.ctrl_wr = bus_cs && bus_wr && (bus_sel == SEL_CTRL);
  assign req.feed_ok = bus_cs && bus_wr && (bus_sel == SEL_FEED) && (bus_wdata == FEED_KEY);
  assign req.data    = bus_wdata;

  gt_window #(.WINDOW_US(WINDOW_US), .CYC_PER_US(CYC_PER_US)) u_window (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .feed_ok (req.feed_ok),
    .win_open(win_open)
  );

  gt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .req     (req),
    .win_open(win_open),
    .expire  (expire),
    .ctrl_q  (ctrl_q),
    .accept  (accept)
  );

  assign reload    = req.feed_ok || accept;
  assign load_code = accept ? req.data : ctrl_q;

  gt_countdown #(
    .CYC_PER_MS(CYC_PER_MS),
    .BASE_MS   (BASE_MS),
    .PULSE_CYC (PULSE_CYC)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .reload   (reload),
    .load_code(load_code),
    .expire   (expire),
    .rst_req  (wd_rst_req)
  );

  assign bus_rdata = (bus_cs && bus_rd && (bus_sel == SEL_CTRL)) ? ctrl_q : 3'd0;
endmodule

// File: rtl/guard_timer_chk.sv
`timescale 1ns/1ps
module guard_timer_chk #(
  parameter int unsigned WIN_CYC   = 6000,
  parameter int unsigned PULSE_CYC = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_sel,
  input logic [2:0] bus_wdata,
  input logic [2:0] bus_rdata,
  input logic       wd_rst_req,
  input logic [2:0] ctrl_q
);
  localparam int unsigned GW = $clog2(WIN_CYC + 2);
  localparam int unsigned HW = $clog2(PULSE_CYC + 2);
  localparam logic [GW-1:0] GSAT = GW'(WIN_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [HW-1:0] hi_q;
  logic          feed_seen, ctrl_seen;

  assign feed_seen = bus_cs && bus_wr && bus_sel && (bus_wdata == 3'd5);
  assign ctrl_seen = bus_cs && bus_wr && !bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= GSAT;
    else if (feed_seen)       gap_q <= GW'(1);
    else if (gap_q != GSAT)   gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_q <= '0;
    else if (wd_rst_req) hi_q <= hi_q + 1'b1;
    else                 hi_q <= '0;
  end

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 3'd0 && !wd_rst_req) |=> !wd_rst_req);

  assert_late_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_seen && gap_q > GW'(WIN_CYC)) |=> (ctrl_q == $past(ctrl_q) || ctrl_q == 3'd0));

  assert_rsvd_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_seen && bus_wdata == 3'd4) |=> (ctrl_q == $past(ctrl_q) || ctrl_q == 3'd0));

  assert_read_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && !bus_sel) |-> bus_rdata == ctrl_q);

  assert_read_feed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && bus_sel) |-> bus_rdata == 3'd0);

  assert_fire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_req) |-> ctrl_q == 3'd0);

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_req) |-> hi_q == HW'(PULSE_CYC));
endmodule

bind guard_timer guard_timer_chk #(
  .WIN_CYC  (WINDOW_US * CYC_PER_US),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wd_rst_req(wd_rst_req),
  .ctrl_q    (ctrl_q)
);

// File: tb/guard_timer_tb.sv
`timescale 1ns/1ps
module guard_timer_tb;
  localparam int CPU = 2;
  localparam int UPM = 2;
  localparam int WUS = 30;
  localparam int PUL = 8;
  localparam int CPM = CPU * UPM;
  localparam int WIN = WUS * CPU;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_cs, bus_wr, bus_rd, bus_sel;
  logic [2:0] bus_wdata;
  logic [2:0] bus_rdata;
  logic       wd_rst_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  guard_timer #(
    .CYC_PER_US(CPU), .US_PER_MS(UPM), .WINDOW_US(WUS),
    .BASE_MS(250), .PULSE_CYC(PUL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_req(wd_rst_req)
  );

  function automatic int exp_ms(input int code);
    case (code)
      1: return 250;
      2: return 500;
      3: return 1000;
      5: return 2000;
      6: return 4000;
      7: return 8000;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [2:0] data);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0; bus_wdata = 3'd0;
  endtask

  task automatic bus_read(input logic sel, output int val);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_sel = sel;
    #0.5;
    val = int'(bus_rdata);
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic read_ctrl(output int val);
    bus_read(1'b0, val);
  endtask

  // Enable a code via feed + control write; returns at the negedge after the control edge.
  task automatic arm(input int code);
    bus_write(1'b1, 3'd5);
    bus_write(1'b0, code[2:0]);
  endtask

  // Wait from a reload edge for expiry and check edge timing, pulse length and clearing.
  task automatic expect_expiry(input string req, input int cyc);
    int v;
    step(cyc - 1);
    chk({req, " low before expiry"}, int'(wd_rst_req), 0);
    step(1);
    chk({req, " high at expiry"}, int'(wd_rst_req), 1);
    read_ctrl(v);
    chk("R9 ctrl cleared on expiry", v, 0);
    step(PUL - 1);
    chk("R9 pulse still high", int'(wd_rst_req), 1);
    step(1);
    chk("R9 pulse ended", int'(wd_rst_req), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int model;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = 1'b0; bus_wdata = 3'd0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R10 / R1: reset state
    read_ctrl(v);
    chk("R1 ctrl after reset", v, 0);
    chk("R10 req after reset", int'(wd_rst_req), 0);

    // R5: control write with no feed since reset is ignored
    bus_write(1'b0, 3'd2);
    read_ctrl(v);
    chk("R5 no feed yet", v, 0);

    // R1: disabled watchdog stays quiet
    begin
      int hits = 0;
      bus_write(1'b1, 3'd5);
      for (int i = 0; i < 3000; i++) begin
        step(1);
        if (wd_rst_req) hits++;
      end
      chk("R1 no request while off", hits, 0);
    end

    // R2: every timeout code runs to expiry
    for (int c = 1; c < 8; c++) begin
      if (c == 4) continue;
      arm(c);
      read_ctrl(v);
      chk("R2 code accepted", v, c);
      expect_expiry("R2", exp_ms(c) * CPM);
    end

    // R8: feed register reads 0, ctrl reads back
    arm(3);
    bus_read(1'b1, v);
    chk("R8 feed reg reads 0", v, 0);
    read_ctrl(v);
    chk("R8 ctrl readback", v, 3);
    arm(0);

    // R4: a wrong feed value does not restart the countdown
    arm(1);
    step(400);
    bus_write(1'b1, 3'd3);
    expect_expiry("R4", 1000 - 401);

    // R3: a valid feed restarts the full timeout
    arm(1);
    step(499);
    bus_write(1'b1, 3'd5);
    expect_expiry("R3", 1000);

    // R7: an accepted control write reloads with the new timeout
    arm(7);
    step(10);
    bus_write(1'b0, 3'd1);
    expect_expiry("R7", 1000);

    // R5: last cycle of window accepted, first cycle after rejected
    bus_write(1'b1, 3'd5);
    step(WIN - 1);
    bus_write(1'b0, 3'd2);
    read_ctrl(v);
    chk("R5 last window cycle accepted", v, 2);
    bus_write(1'b1, 3'd5);
    step(WIN);
    bus_write(1'b0, 3'd3);
    read_ctrl(v);
    chk("R5 first late cycle rejected", v, 2);

    // R6: reserved code ignored inside the window
    bus_write(1'b1, 3'd5);
    bus_write(1'b0, 3'd4);
    read_ctrl(v);
    chk("R6 reserved code ignored", v, 2);

    // Random rounds around the window edge
    model = 2;
    for (int it = 0; it < 60; it++) begin
      int junk, dly, code;
      junk = int'($urandom_range(0, 7));
      if (junk != 5) bus_write(1'b1, junk[2:0]);
      bus_write(1'b1, 3'd5);
      dly = int'($urandom_range(WIN - 6, WIN + 6));
      if (it % 3 == 0) dly = int'($urandom_range(1, 80));
      step(dly - 1);
      code = int'($urandom_range(0, 7));
      bus_write(1'b0, code[2:0]);
      if (dly <= WIN && code != 4) model = code;
      read_ctrl(v);
      chk((code == 4) ? "R6 random ctrl" : "R5 random ctrl", v, model);
      chk("R1 random no request", int'(wd_rst_req), 0);
    end

    // R10: reset mid-countdown clears state
    arm(1);
    step(20);
    rst_n = 1'b0;
    #0.5;
    read_ctrl(v);
    chk("R10 ctrl cleared by reset", v, 0);
    chk("R10 req low in reset", int'(wd_rst_req), 0);
    step(2);
    rst_n = 1'b1;
    step(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule